// File: doc/BRIEF.md
# UART with Fractional Baud Divider and Flow Control

This block is a full-duplex asynchronous serial transceiver. The bit period comes from a 16-bit divider. Its upper 13 bits give a whole number of input-clock cycles, and its lower 3 bits give an eighth-cycle fraction. An accumulator spreads the fraction over the frame, so the average bit time matches the programmed value. The input clock is one of four rates derived from the block clock through a clock-enable prescaler.

Outgoing characters wait in a four-entry transmit FIFO. Received characters go into a four-entry receive FIFO that is read in show-ahead order. The character format can be set as follows:
- 7 or 8 data bits, sent least significant bit first.
- No parity, or one of four parity kinds.
- One or two stop bits.

When flow control is enabled, the clear-to-send input holds back the next character but never cuts one short. The request-to-send output follows the free space in the receive FIFO. Framing, parity and overrun conditions are latched as status flags, and an interrupt output combines them with a receive-data-waiting condition.

Top module: `uart_fracdiv`

## Requirements
- R1: With the input clock at full rate, the start bit of a frame lasts exactly D cycles, where D is the integer part `cfg_div[15:3]`. Each later bit lasts D cycles, plus one extra cycle whenever the running sum of the fraction `cfg_div[2:0]` (in eighths) crosses a multiple of 8. The sum restarts at each start bit. The first n bits of a frame therefore last n·D + floor((n−1)·F/8) cycles, where F is the fraction.
- R2: The block clock `clk` is taken to be twice the reference clock. `cfg_clk_sel` 0, 1, 2 and 3 select an input clock of 2×, 1×, ½× and ¼× the reference. These multiply every bit time by 1, 2, 4 and 8 `clk` cycles respectively.
- R3: `txd` idles high. A frame is a low start bit followed by the data bits, least significant first. There are 7 data bits when `cfg_seven` is 1 and 8 when it is 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. `cfg_par_kind` selects its value: 0 = even (the data plus parity hold an even number of ones), 1 = odd, 2 = always 0, 3 = always 1.
- R5: The frame ends with one high stop bit, or two when `cfg_stop2` is 1.
- R6: The receiver finds the start bit on `rxd`, samples each bit near its middle, and pushes the character into the receive FIFO. In 7-bit mode, bit 7 of the stored character is 0. `rx_data` shows the oldest character, `rx_count` gives the number waiting (at most 4), and `rx_pop` removes one.
- R7: If a stop bit is sampled low, `rx_frame_err` sets. The character is still stored.
- R8: If the received parity bit differs from the value R4 expects, `rx_par_err` sets. The character is still stored.
- R9: A character that completes while the receive FIFO holds 4 entries is dropped, and `rx_overrun` sets. The stored characters are unchanged.
- R10: When `cfg_fc_en` is 1 and `cts_n` is high, no new frame starts. A frame already under way completes in full. When `cts_n` returns low, transmission resumes.
- R11: `rts_n` is low whenever `cfg_fc_en` is 0. When `cfg_fc_en` is 1, `rts_n` is high if the receive FIFO has fewer than 2 free entries and low otherwise.
- R12: The error flags stay set until a `stat_clr` pulse. `irq` is high when `cfg_irq_en[0]` is set and `rx_count` is nonzero, or when `cfg_irq_en[1]` is set and any error flag is set.
- R13: The transmit FIFO holds 4 characters, and `tx_full` is high when all 4 entries are used. A push while it is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the reference rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 16 | Bit-time divider: 13 integer bits, 3 fraction bits |
| cfg_clk_sel | input | 2 | Input clock rate select |
| cfg_seven | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_kind | input | 2 | Parity kind (even, odd, zero, one) |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_fc_en | input | 1 | Enable hardware flow control |
| cfg_irq_en | input | 2 | Interrupt enables: bit 0 data waiting, bit 1 errors |
| stat_clr | input | 1 | Clears the error flags |
| tx_push | input | 1 | Write `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Character to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Remove the oldest received character |
| rx_data | output | 8 | Oldest received character |
| rx_count | output | 3 | Received characters waiting |
| rx_frame_err | output | 1 | Framing error flag |
| rx_par_err | output | 1 | Parity error flag |
| rx_overrun | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Active-low clear to send |
| rts_n | output | 1 | Active-low request to send |

## Verification
The bound checker watches four things on every cycle:
- `txd` stays high whenever the transmitter is idle.
- An idle transmitter stays idle while clear-to-send is withheld.
- The receive count never exceeds the FIFO depth.
- The overrun flag only sets on a cycle when the receive FIFO was full, and request-to-send is deasserted whenever that FIFO is full under flow control.

Only the bench's scenarios can show the rest:
- Exact bit-time arithmetic across the fractional values and the four clock rates.
- The serialised bit order and every parity kind.
- Loopback of every format.
- Error detection on injected bad frames.
- Completion of a frame cut off by clear-to-send mid-character.

// File: rtl/uart_pkg.sv
package uart_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    // Parity kind: 0 even, 1 odd, 2 forced zero, 3 forced one
    function automatic logic par_bit(input logic [7:0] data, input logic seven,
                                     input logic [1:0] kind);
        logic x;
        x = seven ? ^data[6:0] : ^data;
        case (kind)
            2'd0:    return x;
            2'd1:    return ~x;
            2'd2:    return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [W-1:0]             wdata,
    input  logic                     pop,
    output logic [W-1:0]             rdata,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_s;

    fifo_s q, d;
    logic [W-1:0] mem [DEPTH];
    logic wr, rd;

    always_comb begin
        d  = q;
        wr = push && (q.cnt != (AW+1)'(DEPTH));
        rd = pop && (q.cnt != '0);
        if (wr) d.wp = q.wp + 1'b1;
        if (rd) d.rp = q.rp + 1'b1;
        d.cnt = q.cnt + (AW+1)'(wr) - (AW+1)'(rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr) mem[q.wp] <= wdata;
    end

    assign rdata = mem[q.rp];
    assign count = q.cnt;
endmodule

// File: rtl/uart_bitclk.sv
module uart_bitclk #(
    parameter int IW = 13,
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [IW-1:0] load_val,
    input  logic [IW-1:0] div_int,
    input  logic [FW-1:0] div_frac,
    output logic          tick
);
    typedef struct packed {
        logic [IW-1:0] cnt;
        logic [FW-1:0] acc;
    } bclk_s;

    bclk_s q, d;
    logic [FW:0] sum;

    always_comb begin
        d    = q;
        tick = 1'b0;
        sum  = {1'b0, q.acc} + {1'b0, div_frac};
        if (load) begin
            d.cnt = load_val;
            d.acc = '0;
        end else if (en) begin
            if (q.cnt <= IW'(1)) begin
                tick  = 1'b1;
                d.acc = sum[FW-1:0];
                d.cnt = div_int + IW'(sum[FW]);
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       avail,
    input  logic       cts_ok,
    input  logic [7:0] din,
    input  logic       seven,
    input  logic       par_en,
    input  logic [1:0] par_kind,
    input  logic       stop2,
    output logic       pop,
    output logic       load,
    output logic       busy,
    output logic       txd
);
    typedef struct packed {
        phase_e     ph;
        logic [7:0] sh;
        logic [2:0] nb;
        logic       pb;
        logic       sb;
        logic       txd;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d    = q;
        pop  = 1'b0;
        load = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                d.txd = 1'b1;
                if (en && avail && cts_ok) begin
                    pop   = 1'b1;
                    load  = 1'b1;
                    d.sh  = din;
                    d.pb  = par_bit(din, seven, par_kind);
                    d.txd = 1'b0;
                    d.ph  = PH_START;
                end
            end
            PH_START: if (tick) begin
                d.txd = q.sh[0];
                d.sh  = q.sh >> 1;
                d.nb  = '0;
                d.ph  = PH_DATA;
            end
            PH_DATA: if (tick) begin
                if (q.nb == (seven ? 3'd6 : 3'd7)) begin
                    d.sb = stop2;
                    if (par_en) begin
                        d.txd = q.pb;
                        d.ph  = PH_PAR;
                    end else begin
                        d.txd = 1'b1;
                        d.ph  = PH_STOP;
                    end
                end else begin
                    d.nb  = q.nb + 1'b1;
                    d.txd = q.sh[0];
                    d.sh  = q.sh >> 1;
                end
            end
            PH_PAR: if (tick) begin
                d.txd = 1'b1;
                d.ph  = PH_STOP;
            end
            default: if (tick) begin
                if (q.sb) d.sb = 1'b0;
                else      d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, sh: '0, nb: '0, pb: 1'b0, sb: 1'b0, txd: 1'b1};
        else        q <= d;
    end

    assign txd  = q.txd;
    assign busy = (q.ph != PH_IDLE);
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd_s,
    input  logic       seven,
    input  logic       par_en,
    input  logic [1:0] par_kind,
    input  logic       stop2,
    output logic       load,
    output logic       push,
    output logic [7:0] dout,
    output logic       ferr,
    output logic       perr
);
    typedef struct packed {
        phase_e     ph;
        logic [7:0] sh;
        logic [2:0] nb;
        logic       pb;
        logic       fe;
        logic       sb;
    } rx_s;

    rx_s  q, d;
    logic fe_n;

    always_comb begin
        d    = q;
        load = 1'b0;
        push = 1'b0;
        fe_n = q.fe | ~rxd_s;
        case (q.ph)
            PH_IDLE: if (en && !rxd_s) begin
                load = 1'b1;
                d.ph = PH_START;
            end
            PH_START: if (tick) begin
                d.sh = '0;
                d.nb = '0;
                d.ph = rxd_s ? PH_IDLE : PH_DATA;
            end
            PH_DATA: if (tick) begin
                d.sh = seven ? {1'b0, rxd_s, q.sh[6:1]} : {rxd_s, q.sh[7:1]};
                if (q.nb == (seven ? 3'd6 : 3'd7)) begin
                    d.fe = 1'b0;
                    d.sb = stop2;
                    d.ph = par_en ? PH_PAR : PH_STOP;
                end else begin
                    d.nb = q.nb + 1'b1;
                end
            end
            PH_PAR: if (tick) begin
                d.pb = rxd_s;
                d.ph = PH_STOP;
            end
            default: if (tick) begin
                d.fe = fe_n;
                if (q.sb) d.sb = 1'b0;
                else begin
                    push = 1'b1;
                    d.ph = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, sh: '0, nb: '0, pb: 1'b0, fe: 1'b0, sb: 1'b0};
        else        q <= d;
    end

    assign dout = q.sh;
    assign ferr = fe_n;
    assign perr = par_en && (q.pb != par_bit(q.sh, seven, par_kind));
endmodule

// File: rtl/uart_fracdiv.sv
module uart_fracdiv #(
    parameter int DEPTH    = 4,
    parameter int IW       = 13,
    parameter int FW       = 3,
    parameter int RTS_ROOM = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IW+FW-1:0]          cfg_div,
    input  logic [1:0]                cfg_clk_sel,
    input  logic                      cfg_seven,
    input  logic                      cfg_par_en,
    input  logic [1:0]                cfg_par_kind,
    input  logic                      cfg_stop2,
    input  logic                      cfg_fc_en,
    input  logic [1:0]                cfg_irq_en,
    input  logic                      stat_clr,
    input  logic                      tx_push,
    input  logic [7:0]                tx_data,
    output logic                      tx_full,
    input  logic                      rx_pop,
    output logic [7:0]                rx_data,
    output logic [$clog2(DEPTH):0]    rx_count,
    output logic                      rx_frame_err,
    output logic                      rx_par_err,
    output logic                      rx_overrun,
    output logic                      irq,
    output logic                      txd,
    input  logic                      rxd,
    input  logic                      cts_n,
    output logic                      rts_n
);
    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [2:0] pre;
        logic       rx_m;
        logic       rx_s;
        logic       fe;
        logic       pe;
        logic       ov;
    } top_s;

    top_s q, d;
    logic en;
    logic [IW-1:0] div_int;
    logic [FW-1:0] div_frac;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [7:0]    tx_dout, rx_dout;
    logic tx_pop, tx_load, tx_tick, tx_busy;
    logic rx_load, rx_tick, rx_push, rx_ferr, rx_perr;

    assign div_int  = cfg_div[IW+FW-1:FW];
    assign div_frac = cfg_div[FW-1:0];

    always_comb begin
        d      = q;
        d.pre  = q.pre + 3'd1;
        d.rx_m = rxd;
        d.rx_s = q.rx_m;
        d.fe   = (q.fe & ~stat_clr) | (rx_push & rx_ferr);
        d.pe   = (q.pe & ~stat_clr) | (rx_push & rx_perr);
        d.ov   = (q.ov & ~stat_clr) | (rx_push & (rx_cnt == CW'(DEPTH)));
        case (cfg_clk_sel)
            2'd0:    en = 1'b1;
            2'd1:    en = q.pre[0];
            2'd2:    en = &q.pre[1:0];
            default: en = &q.pre;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{pre: '0, rx_m: 1'b1, rx_s: 1'b1, fe: 1'b0, pe: 1'b0, ov: 1'b0};
        else        q <= d;
    end

    uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_dout), .count(tx_cnt)
    );

    uart_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_dout),
        .pop(rx_pop), .rdata(rx_data), .count(rx_cnt)
    );

    uart_bitclk #(.IW(IW), .FW(FW)) u_tx_clk (
        .clk(clk), .rst_n(rst_n), .en(en), .load(tx_load), .load_val(div_int),
        .div_int(div_int), .div_frac(div_frac), .tick(tx_tick)
    );

    uart_bitclk #(.IW(IW), .FW(FW)) u_rx_clk (
        .clk(clk), .rst_n(rst_n), .en(en), .load(rx_load), .load_val(div_int >> 1),
        .div_int(div_int), .div_frac(div_frac), .tick(rx_tick)
    );

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tx_tick),
        .avail(tx_cnt != '0), .cts_ok(!cfg_fc_en || !cts_n), .din(tx_dout),
        .seven(cfg_seven), .par_en(cfg_par_en), .par_kind(cfg_par_kind),
        .stop2(cfg_stop2), .pop(tx_pop), .load(tx_load), .busy(tx_busy), .txd(txd)
    );

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(rx_tick), .rxd_s(q.rx_s),
        .seven(cfg_seven), .par_en(cfg_par_en), .par_kind(cfg_par_kind),
        .stop2(cfg_stop2), .load(rx_load), .push(rx_push), .dout(rx_dout),
        .ferr(rx_ferr), .perr(rx_perr)
    );

    assign tx_full      = (tx_cnt == CW'(DEPTH));
    assign rx_count     = rx_cnt;
    assign rx_frame_err = q.fe;
    assign rx_par_err   = q.pe;
    assign rx_overrun   = q.ov;
    assign irq          = (cfg_irq_en[0] && rx_cnt != '0) ||
                          (cfg_irq_en[1] && (q.fe || q.pe || q.ov));
    assign rts_n        = cfg_fc_en && ((CW'(DEPTH) - rx_cnt) < CW'(RTS_ROOM));
endmodule

// File: rtl/uart_fracdiv_sva.sv
module uart_fracdiv_sva #(
    parameter int DEPTH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_fc_en,
    input logic                    cts_n,
    input logic                    txd,
    input logic                    tx_busy,
    input logic [$clog2(DEPTH):0]  rx_count,
    input logic                    rts_n,
    input logic                    rx_overrun
);
    localparam int CW = $clog2(DEPTH) + 1;

    assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    assert_cts_holds_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fc_en && cts_n && !tx_busy) |=> !tx_busy);

    assert_rx_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    assert_rts_when_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fc_en && rx_count == CW'(DEPTH)) |-> rts_n);

    assert_overrun_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_count) == CW'(DEPTH));
endmodule

bind uart_fracdiv uart_fracdiv_sva #(.DEPTH(DEPTH)) u_sva (.*);

// File: tb/uart_fracdiv_tb.sv
module uart_fracdiv_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cfg_div = {13'd16, 3'd0};
    logic [1:0]  cfg_clk_sel = 2'd0;
    logic cfg_seven = 1'b0, cfg_par_en = 1'b0, cfg_stop2 = 1'b0, cfg_fc_en = 1'b0;
    logic [1:0] cfg_par_kind = 2'd0, cfg_irq_en = 2'd0;
    logic stat_clr = 1'b0, tx_push = 1'b0, rx_pop = 1'b0, cts_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_full, rx_frame_err, rx_par_err, rx_overrun, irq, txd, rts_n;
    logic [7:0] rx_data;
    logic [2:0] rx_count;
    logic loop = 1'b1, rxd_b = 1'b1;
    logic rxd;
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz
    assign rxd = loop ? txd : rxd_b;

    uart_fracdiv u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_clk_sel(cfg_clk_sel),
        .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_par_kind(cfg_par_kind),
        .cfg_stop2(cfg_stop2), .cfg_fc_en(cfg_fc_en), .cfg_irq_en(cfg_irq_en),
        .stat_clr(stat_clr), .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_count(rx_count),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_overrun(rx_overrun),
        .irq(irq), .txd(txd), .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic bpar(input logic [7:0] dv, input int nd, input int kind);
        logic x = 1'b0;
        for (int i = 0; i < nd; i++) x = x ^ dv[i];
        case (kind)
            0: return x;
            1: return ~x;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic push(input logic [7:0] v);
        @(negedge clk); tx_data = v; tx_push = 1'b1;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic wait_cnt(input int n);
        int t = 0;
        while (rx_count != 3'(n) && t < 5000) begin @(negedge clk); t++; end
    endtask

    task automatic drain();
        repeat (20) @(negedge clk);
        while (rx_count != 0) pop();
    endtask

    task automatic clear_flags();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    // capture n bits of one frame at 16 cycles per bit
    task automatic capture(input int n, output logic [11:0] b);
        b = '1;
        while (txd) @(negedge clk);
        repeat (8) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            b[i] = txd;
            if (i < n - 1) repeat (16) @(negedge clk);
        end
    endtask

    task automatic measure_low(output int cyc);
        cyc = 0;
        while (txd) @(negedge clk);
        while (!txd) begin cyc++; @(negedge clk); end
    endtask

    task automatic drive_frame(input logic [7:0] dv, input logic p, input logic s);
        logic [10:0] f;
        f = {s, p, dv, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk); rxd_b = f[i];
            repeat (15) @(negedge clk);
        end
        @(negedge clk); rxd_b = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [11:0] got, exp;
        int idx, cyc, low8, low9, mult;
        logic [7:0] vals [3];
        int ti [6], tf [6], ts [6];
        vals[0] = 8'h45; vals[1] = 8'hA3; vals[2] = 8'h3C;
        ti[0] = 8;  tf[0] = 0; ts[0] = 0;
        ti[1] = 8;  tf[1] = 4; ts[1] = 0;
        ti[2] = 8;  tf[2] = 7; ts[2] = 0;
        ti[3] = 10; tf[3] = 3; ts[3] = 1;
        ti[4] = 9;  tf[4] = 5; ts[4] = 2;
        ti[5] = 8;  tf[5] = 1; ts[5] = 3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R3 reset txd", txd, 1);
        chk("R6 reset rx_count", rx_count, 0);
        chk("R13 reset tx_full", tx_full, 0);
        chk("R12 reset irq", irq, 0);
        chk("R11 reset rts_n", rts_n, 0);
        chk("R7 reset frame flag", rx_frame_err, 0);
        chk("R9 reset overrun flag", rx_overrun, 0);

        // R3 R4 R5 R6: format sweep in loopback (includes 7-bit 0x45 odd, two stops)
        for (int sv = 0; sv < 2; sv++)
            for (int pk = 0; pk < 5; pk++)
                for (int st = 0; st < 2; st++)
                    for (int vi = 0; vi < 3; vi++) begin
                        int nd, nb;
                        @(negedge clk);
                        cfg_seven = sv[0]; cfg_par_en = (pk != 4);
                        cfg_par_kind = 2'(pk); cfg_stop2 = st[0];
                        nd = sv ? 7 : 8;
                        nb = 1 + nd + (pk != 4 ? 1 : 0) + 1 + st;
                        exp = '1; exp[0] = 1'b0;
                        for (int i = 0; i < nd; i++) exp[1 + i] = vals[vi][i];
                        idx = 1 + nd;
                        if (pk != 4) exp[idx] = bpar(vals[vi], nd, pk);
                        push(vals[vi]);
                        capture(nb, got);
                        chk($sformatf("R3 R4 R5 frame bits sv=%0d pk=%0d st=%0d", sv, pk, st), got, exp);
                        wait_cnt(1);
                        chk($sformatf("R6 loopback data sv=%0d pk=%0d st=%0d", sv, pk, st),
                            rx_data, sv ? (vals[vi] & 8'h7F) : vals[vi]);
                        pop();
                        repeat (40) @(negedge clk);
                    end

        // R1 R2: fractional bit timing and clock select, 8N1
        @(negedge clk);
        cfg_seven = 1'b0; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cfg_div = {13'(ti[k]), 3'(tf[k])};
            cfg_clk_sel = 2'(ts[k]);
            mult = 1 << ts[k];
            low9 = (9 * ti[k] + (8 * tf[k]) / 8) * mult;
            low8 = (8 * ti[k] + (7 * tf[k]) / 8) * mult;
            push(8'h00);
            measure_low(cyc);
            chk($sformatf("R1 R2 nine-bit low div=%0d.%0d/8 sel=%0d", ti[k], tf[k], ts[k]), cyc, low9);
            wait_cnt(1);
            drain();
            push(8'h80);
            measure_low(cyc);
            chk($sformatf("R1 R2 eight-bit low div=%0d.%0d/8 sel=%0d", ti[k], tf[k], ts[k]), cyc, low8);
            wait_cnt(1);
            drain();
        end
        // R1 loopback at a fractional divider with prescaler
        @(negedge clk); cfg_div = {13'd8, 3'd4}; cfg_clk_sel = 2'd2;
        push(8'h5A);
        wait_cnt(1);
        chk("R1 loopback at fractional divider", rx_data, 8'h5A);
        drain();
        repeat (400) @(negedge clk);

        // R7 R8: injected frames, 8 bits, even parity, 16 cycles per bit
        @(negedge clk);
        cfg_div = {13'd16, 3'd0}; cfg_clk_sel = 2'd0;
        cfg_par_en = 1'b1; cfg_par_kind = 2'd0; loop = 1'b0;
        cfg_irq_en = 2'b10;
        drive_frame(8'h5A, 1'b0, 1'b0);
        chk("R7 framing error on low stop", rx_frame_err, 1);
        chk("R8 no parity error on good parity", rx_par_err, 0);
        chk("R12 irq from error flag", irq, 1);
        chk("R7 character still stored", rx_data, 8'h5A);
        drain();
        clear_flags();
        chk("R12 flag cleared by stat_clr", rx_frame_err, 0);
        chk("R12 irq drops after clear", irq, 0);
        drive_frame(8'h5A, 1'b1, 1'b1);
        chk("R8 parity error on mismatch", rx_par_err, 1);
        chk("R7 no framing error on good stop", rx_frame_err, 0);
        chk("R8 character still stored", rx_count, 1);
        drain();
        clear_flags();

        // R9 R11 R12: overrun and request-to-send
        @(negedge clk);
        loop = 1'b1; cfg_par_en = 1'b0; cfg_div = {13'd8, 3'd0};
        cfg_fc_en = 1'b0; cfg_irq_en = 2'b01;
        for (int i = 0; i < 4; i++) push(8'h10 + 8'(i));
        wait_cnt(4);
        chk("R6 four characters queued", rx_count, 4);
        chk("R11 rts_n low with flow control off", rts_n, 0);
        chk("R12 irq on data waiting", irq, 1);
        push(8'h99);
        repeat (250) @(negedge clk);
        chk("R9 overrun flag set", rx_overrun, 1);
        chk("R9 count unchanged", rx_count, 4);
        chk("R9 oldest character kept", rx_data, 8'h10);
        @(negedge clk); cfg_fc_en = 1'b1;
        @(negedge clk);
        chk("R11 rts_n high when FIFO full", rts_n, 1);
        pop();
        chk("R11 rts_n high with one free entry", rts_n, 1);
        pop();
        chk("R11 rts_n low with two free entries", rts_n, 0);
        chk("R9 later character order", rx_data, 8'h12);
        drain();
        clear_flags();
        chk("R12 overrun cleared", rx_overrun, 0);

        // R10 R13: clear-to-send gating and transmit FIFO depth
        @(negedge clk); cts_n = 1'b1;
        for (int i = 0; i < 5; i++) push(8'h21 + 8'(i));
        chk("R13 tx_full after four pushes", tx_full, 1);
        cyc = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd) cyc++; end
        chk("R10 no frame while cts_n high", cyc, 0);
        @(negedge clk); cts_n = 1'b0;
        wait_cnt(4);
        repeat (300) @(negedge clk);
        chk("R13 fifth push dropped", rx_count, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R13 queued character order", rx_data, 8'h21 + 8'(i));
            pop();
        end
        // R10: frame in flight completes
        push(8'h66);
        while (txd) @(negedge clk);
        cts_n = 1'b1;
        repeat (300) @(negedge clk);
        chk("R10 frame in flight completes", rx_count, 1);
        chk("R10 completed character", rx_data, 8'h66);
        push(8'h77);
        repeat (300) @(negedge clk);
        chk("R10 next frame held", rx_count, 1);
        @(negedge clk); cts_n = 1'b0;
        wait_cnt(2);
        chk("R10 resumes after cts_n low", rx_count, 2);
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule